// File: doc/BRIEF.md
# Four-Bit Arithmetic and Logic Unit with Status Flags

This block is a purely combinational arithmetic and logic unit. It takes two 4-bit operands and a 3-bit operation select. It returns a 4-bit result and four status flags: zero, carry, signed overflow and negative. The block has no clock and no reset. Every output follows the inputs after the gate delay.

Addition and subtraction share one ripple-carry chain. The chain is made of full-adder cells, and each cell is built structurally from nine two-input NAND gates. To subtract, each B bit is inverted through an XOR gate controlled by a subtract line, and the same line drives the carry into stage 0. A per-bit logic bank runs beside the adder and also supplies the pass-through paths. A final multiplexer picks either the adder sum or the logic bank output.

The flags are meant to feed the conditional decisions of a surrounding datapath. Zero and negative always describe the selected result. Carry and overflow have meaning only for the two arithmetic codes and are held at 0 for every other code.

Top module: `alu4_core`

## Requirements
- R1: Select code 3'b000 gives result = (A + B) mod 16.
- R2: Select code 3'b100 gives result = (A - B) mod 16, computed as A + ~B + 1.
- R3: Select code 3'b001 gives A | B, 3'b010 gives A ^ B, and 3'b101 gives A & B.
- R4: Select code 3'b011 gives ~A, and the value of B has no effect on any output.
- R5: Select code 3'b110 passes A to the result unchanged, and 3'b111 passes B unchanged.
- R6: flag_zero is 1 exactly when all four result bits are 0, for every select code.
- R7: flag_neg equals result bit 3, for every select code.
- R8: For 3'b000, flag_carry is the carry out of the unsigned 4-bit sum (A + B > 15). For 3'b100, flag_carry is the raw adder carry out, which is 1 exactly when A >= B unsigned (no borrow).
- R9: For 3'b000 and 3'b100, flag_ovf is 1 exactly when the true two's complement result lies outside -8..7. This equals the XOR of the carry into bit 3 and the carry out of bit 3.
- R10: For all six non-arithmetic select codes, flag_carry and flag_ovf are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 4 | First operand (A) |
| op_b | input | 4 | Second operand (B) |
| op_sel | input | 3 | Operation select code |
| result | output | 4 | Selected result |
| flag_zero | output | 1 | Result is all zeros |
| flag_carry | output | 1 | Adder carry out (arithmetic codes only) |
| flag_ovf | output | 1 | Signed overflow (arithmetic codes only) |
| flag_neg | output | 1 | Most significant result bit |

## Verification
The block holds no state, so any fault shows up on the outputs as soon as the combinational paths settle for the input vector that exposes it. A wrong NAND in one cell corrupts the sum or the carry of that bit position only for operand pairs that activate that gate. A break in the ripple chain appears as a wrong high result bit, a wrong carry or a wrong overflow flag, but only when a carry actually propagates. For this reason every operand pair is applied under every select code, followed by random and corner vectors. Each result field and each flag is compared against a reference computed from integer arithmetic.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

    localparam int ALU_W = 4;
    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_ADD   = 3'b000,
        SEL_OR    = 3'b001,
        SEL_XOR   = 3'b010,
        SEL_NOTA  = 3'b011,
        SEL_SUB   = 3'b100,
        SEL_AND   = 3'b101,
        SEL_PASSA = 3'b110,
        SEL_PASSB = 3'b111
    } alu_sel_e;

    typedef struct packed {
        logic zero;
        logic carry;
        logic ovf;
        logic neg;
    } alu_flags_t;

    function automatic logic sel_is_arith(alu_sel_e s);
        return (s == SEL_ADD) || (s == SEL_SUB);
    endfunction

    function automatic logic sel_is_sub(alu_sel_e s);
        return s == SEL_SUB;
    endfunction

endpackage

// File: rtl/alu4_fa_nand.sv
module alu4_fa_nand (
    input  logic a,
    input  logic b,
    input  logic cin,
    output logic sum,
    output logic cout
);
    logic n1, n2, n3, n4, n5, n6, n7;

    assign n1   = ~(a   & b);
    assign n2   = ~(a   & n1);
    assign n3   = ~(b   & n1);
    assign n4   = ~(n2  & n3);
    assign n5   = ~(n4  & cin);
    assign n6   = ~(n4  & n5);
    assign n7   = ~(cin & n5);
    assign sum  = ~(n6  & n7);
    assign cout = ~(n1  & n5);

    // Cell-level check of the NAND network against the full-adder truth table (R1, R2).
    always_comb begin
        if (!$isunknown({a, b, cin})) begin
            assert_fa_cell_R1: assert ({cout, sum} == 2'({1'b0, a} + {1'b0, b} + {1'b0, cin}))
                else $error("full-adder cell mismatch");
        end
    end
endmodule

// File: rtl/alu4_addsub.sv
module alu4_addsub #(
    parameter int W = alu4_pkg::ALU_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         cin_msb
);
    logic [W-1:0] b_eff;
    logic [W:0]   chain;

    assign b_eff    = b ^ {W{sub}};
    assign chain[0] = sub;

    generate
        for (genvar i = 0; i < W; i++) begin : g_stage
            alu4_fa_nand u_fa (
                .a   (a[i]),
                .b   (b_eff[i]),
                .cin (chain[i]),
                .sum (sum[i]),
                .cout(chain[i+1])
            );
        end
    endgenerate

    assign cout    = chain[W];
    assign cin_msb = chain[W-1];

    // Whole-chain check against integer add/subtract (R1, R2, R8).
    always_comb begin
        if (!$isunknown({a, b, sub})) begin
            assert_chain_R8: assert ({cout, sum} ==
                (sub ? (W+1)'({1'b0, a} + {1'b0, ~b} + 1'b1)
                     : (W+1)'({1'b0, a} + {1'b0, b})))
                else $error("ripple chain mismatch");
        end
    end
endmodule

// File: rtl/alu4_logic.sv
module alu4_logic #(
    parameter int W = alu4_pkg::ALU_W
) (
    input  logic [W-1:0]       a,
    input  logic [W-1:0]       b,
    input  alu4_pkg::alu_sel_e sel,
    output logic [W-1:0]       y
);
    import alu4_pkg::*;

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic t_and, t_or, t_xor, t_not;
            assign t_and = a[i] & b[i];
            assign t_or  = a[i] | b[i];
            assign t_xor = a[i] ^ b[i];
            assign t_not = ~a[i];
            always_comb begin
                unique case (sel)
                    SEL_OR:    y[i] = t_or;
                    SEL_XOR:   y[i] = t_xor;
                    SEL_NOTA:  y[i] = t_not;
                    SEL_AND:   y[i] = t_and;
                    SEL_PASSA: y[i] = a[i];
                    SEL_PASSB: y[i] = b[i];
                    default:   y[i] = 1'b0;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/alu4_core.sv
module alu4_core (
    input  logic [3:0] op_a,
    input  logic [3:0] op_b,
    input  logic [2:0] op_sel,
    output logic [3:0] result,
    output logic       flag_zero,
    output logic       flag_carry,
    output logic       flag_ovf,
    output logic       flag_neg
);
    import alu4_pkg::*;

    localparam int W = ALU_W;

    alu_sel_e   sel;
    logic       arith;
    logic [W-1:0] add_sum, log_y;
    logic       add_cout, add_cin_msb;
    alu_flags_t flg;

    assign sel   = alu_sel_e'(op_sel);
    assign arith = sel_is_arith(sel);

    alu4_addsub #(.W(W)) u_addsub (
        .a      (op_a),
        .b      (op_b),
        .sub    (sel_is_sub(sel)),
        .sum    (add_sum),
        .cout   (add_cout),
        .cin_msb(add_cin_msb)
    );

    alu4_logic #(.W(W)) u_logic (
        .a  (op_a),
        .b  (op_b),
        .sel(sel),
        .y  (log_y)
    );

    assign result    = arith ? add_sum : log_y;

    assign flg.zero  = ~|result;
    assign flg.neg   = result[W-1];
    assign flg.carry = arith & add_cout;
    assign flg.ovf   = arith & (add_cin_msb ^ add_cout);

    assign flag_zero  = flg.zero;
    assign flag_carry = flg.carry;
    assign flag_ovf   = flg.ovf;
    assign flag_neg   = flg.neg;

    always_comb begin
        if (!$isunknown({op_a, op_b, op_sel})) begin
            assert_quiet_flags_R10: assert (arith || (!flag_carry && !flag_ovf))
                else $error("carry/overflow set on non-arithmetic code");
            assert_signed_ovf_R9: assert (!arith || !flag_ovf ||
                    ((sel == SEL_ADD) ? (op_a[W-1] == op_b[W-1]) : (op_a[W-1] != op_b[W-1])))
                else $error("overflow with operand signs that cannot overflow");
            assert_zero_flag_R6: assert (flag_zero == (result == '0))
                else $error("zero flag disagrees with result");
            assert_pass_R5: assert (sel != SEL_PASSA || result == op_a)
                else $error("pass A path altered operand");
        end
    end
endmodule

// File: tb/alu4_core_tb.sv
module alu4_core_tb;

    localparam time CLK_HALF = 4ns;

    logic       clk = 1'b0;
    logic [3:0] op_a = '0, op_b = '0;
    logic [2:0] op_sel = '0;
    logic [3:0] result;
    logic       flag_zero, flag_carry, flag_ovf, flag_neg;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_HALF) clk = ~clk;

    alu4_core u_dut (
        .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
        .result(result), .flag_zero(flag_zero), .flag_carry(flag_carry),
        .flag_ovf(flag_ovf), .flag_neg(flag_neg)
    );

    function automatic int sval(input logic [3:0] v);
        return v[3] ? int'(v) - 16 : int'(v);
    endfunction

    // Returns {result[3:0], zero, carry, ovf, neg}.
    function automatic logic [7:0] ref_model(input logic [3:0] a, input logic [3:0] b,
                                             input logic [2:0] s);
        int u, sg;
        logic [3:0] r;
        logic c, v;
        c = 1'b0; v = 1'b0;
        case (s)
            3'b000: begin u = int'(a) + int'(b); sg = sval(a) + sval(b);
                          r = 4'(u); c = (u > 15); v = (sg > 7) || (sg < -8); end
            3'b100: begin u = int'(a) - int'(b); sg = sval(a) - sval(b);
                          r = 4'(u); c = (a >= b); v = (sg > 7) || (sg < -8); end
            3'b001: r = a | b;
            3'b010: r = a ^ b;
            3'b011: r = ~a;
            3'b101: r = a & b;
            3'b110: r = a;
            default: r = b;
        endcase
        return {r, (r == 4'd0), c, v, r[3]};
    endfunction

    function automatic string req_of(input logic [2:0] s);
        case (s)
            3'b000: return "R1";
            3'b100: return "R2";
            3'b011: return "R4";
            3'b110, 3'b111: return "R5";
            default: return "R3";
        endcase
    endfunction

    task automatic check_bit(input string req, input string what, input logic act,
                             input logic exp, input logic [3:0] a, input logic [3:0] b,
                             input logic [2:0] s);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s a=%0d b=%0d sel=%b actual=%b expected=%b",
                     req, what, a, b, s, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] a, input logic [3:0] b, input logic [2:0] s);
        logic [7:0] e;
        bit arith;
        @(posedge clk);
        op_a = a; op_b = b; op_sel = s;
        @(negedge clk);
        e = ref_model(a, b, s);
        arith = (s == 3'b000) || (s == 3'b100);
        checks++;
        if (result !== e[7:4]) begin
            errors++;
            $display("FAIL %s result a=%0d b=%0d sel=%b actual=%0d expected=%0d",
                     req_of(s), a, b, s, result, e[7:4]);
        end
        check_bit("R6", "zero", flag_zero, e[3], a, b, s);
        check_bit(arith ? "R8" : "R10", "carry", flag_carry, e[2], a, b, s);
        check_bit(arith ? "R9" : "R10", "ovf", flag_ovf, e[1], a, b, s);
        check_bit("R7", "neg", flag_neg, e[0], a, b, s);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // Initial quiescent vector (all-zero ADD): result 0, only zero flag set.
        @(negedge clk);
        check_bit("R6", "zero@start", flag_zero, 1'b1, 4'd0, 4'd0, 3'd0);
        check_bit("R10", "carry@start", flag_carry, 1'b0, 4'd0, 4'd0, 3'd0);

        // Directed corners: R8 carry, R9 overflow, R2 borrow, R4 B-independence.
        apply(4'd15, 4'd1, 3'b000);
        apply(4'd7,  4'd1, 3'b000);
        apply(4'd8,  4'd8, 3'b000);
        apply(4'd8,  4'd1, 3'b100);
        apply(4'd7,  4'd8, 3'b100);
        apply(4'd3,  4'd3, 3'b100);
        apply(4'd0,  4'd1, 3'b100);
        apply(4'd15, 4'd0, 3'b011);
        apply(4'd15, 4'd9, 3'b011);

        // Exhaustive sweep over every select code and operand pair.
        for (int s = 0; s < 8; s++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    apply(4'(a), 4'(b), 3'(s));

        // Random vectors from the fixed seed.
        for (int k = 0; k < 300; k++)
            apply(4'($urandom), 4'($urandom), 3'($urandom));

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_HALF * 2 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule